// File: doc/BRIEF.md
# Chained-Carry Vector Lane Adder

This block adds or subtracts two 128-bit vectors, split into four 32-bit lanes, and passes a carry from lane to lane. Lane 0 is computed first. The carry out of each lane becomes the carry in of the lane above it, so the whole vector acts as one wide add-with-carry or subtract-with-borrow. Subtraction uses the same adder and inverts the second operand.

The starting carry comes from one of two places. It can be the C bit of the incoming condition flags. It can also be a constant: 0 for add, 1 for subtract. A skip-first-beat indication turns the constant-carry variant into the flag-carry variant.

A per-byte predicate mask controls the work:
- It decides which lanes take part in the carry chain.
- It decides which destination bytes are overwritten. All other bytes keep the old destination value.

When the flags are written, N, Z and V are cleared and C is set to the final carry. A start strobe captures the operands. One clock later the merged result, the new flags, a flag write-enable and a one-cycle done strobe are presented.

Top module: `lane_carry_adder`

## Requirements
- R1: Lane k (k = 0..3, bits 32k+31..32k) computes srcA lane + operand-B lane + carry-in as a 33-bit sum. Bit 32 of that sum is the lane's carry out, and it is the carry in of lane k+1.
- R2: When subMode=1, operand B is srcB with every bit inverted. When subMode=0, operand B is srcB unchanged.
- R3: The initial carry (the carry in of lane 0) is nzcvIn[1] (the C flag) when fixedCarry=0. When fixedCarry=1 and skipFirst=0, it is the value of subMode (0 for add, 1 for subtract).
- R4: When skipFirst=1, a request with fixedCarry=1 produces exactly the same outputs as the same request with fixedCarry=0.
- R5: Lane k is active when byteMask[4k] is 1. An inactive lane passes its carry in to the next lane unchanged. Its own carry out is discarded.
- R6: destOut byte j (bits 8j+7..8j) takes the lane-sum byte when byteMask[j]=1. Otherwise it takes oldDest byte j.
- R7: flagWe is 1 exactly when at least one lane is active, or when fixedCarry=1 and skipFirst=0.
- R8: NZCV is encoded as bit 3=N, bit 2=Z, bit 1=C, bit 0=V. When flagWe=1, nzcvOut has N, Z and V at 0 and C equal to the carry out of the chain after lane 3. When flagWe=0, nzcvOut equals nzcvIn.
- R9: done is 1 in the cycle after start is sampled and 0 otherwise. destOut, nzcvOut and flagWe take their new values in that same cycle and hold them until the next start. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture request; the operands are sampled on this edge |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector (inverted in subtract mode) |
| oldDest | input | 128 | Prior destination value, kept in unmasked bytes |
| byteMask | input | 16 | Per-byte predicate |
| subMode | input | 1 | 1 = subtract-with-carry, 0 = add-with-carry |
| fixedCarry | input | 1 | 1 = constant initial carry |
| skipFirst | input | 1 | First beat skipped; cancels fixedCarry |
| nzcvIn | input | 4 | Current flags {N,Z,C,V} |
| destOut | output | 128 | Merged destination vector |
| nzcvOut | output | 4 | New flags {N,Z,C,V} |
| flagWe | output | 1 | Flags must be written |
| done | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach is a carry that has to cross an inactive lane. Random masks seldom pair a disabled lane with operands whose carry into that lane matters. Directed cases cover this: all-ones plus one with every lane active, and the same pattern with lane 1 switched off so the lane-0 carry must skip over it. A second hard case is a constant-carry request with skip-first-beat set and an empty mask, where no flag write may occur. It is driven explicitly, and the random loop also covers all combinations of the three mode bits against a bench reference model.

// File: rtl/lca_pkg.sv
package lca_pkg;
  // NZCV bit positions
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef struct packed {
    logic load;        // capture results this edge
    logic inv;         // invert second operand
    logic carryInit;   // carry into lane 0
    logic writeFlags;  // flag update requested
  } ctrlStrobes_t;
endpackage

// File: rtl/lca_ctrl.sv
module lca_ctrl #(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  subMode,
  input  logic                  fixedCarry,
  input  logic                  skipFirst,
  input  logic [3:0]            nzcvIn,
  input  logic [LANES-1:0]      laneActive,
  output lca_pkg::ctrlStrobes_t strobes,
  output logic                  done
);
  logic effFixed;

  always_comb begin
    // skipping the first beat turns the constant-carry form into the flag-carry form
    effFixed           = fixedCarry & ~skipFirst;
    strobes.load       = start;
    strobes.inv        = subMode;
    strobes.carryInit  = effFixed ? subMode : nzcvIn[lca_pkg::FLAG_C];
    strobes.writeFlags = effFixed | (|laneActive);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= start;
  end
endmodule

// File: rtl/lca_datapath.sv
module lca_datapath #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  lca_pkg::ctrlStrobes_t  strobes,
  input  logic [LANES*LANE_W-1:0] srcA,
  input  logic [LANES*LANE_W-1:0] srcB,
  input  logic [LANES*LANE_W-1:0] oldDest,
  input  logic [LANES*LANE_W/8-1:0] byteMask,
  input  logic [3:0]             nzcvIn,
  output logic [LANES-1:0]       laneActive,
  output logic [LANES*LANE_W-1:0] destOut,
  output logic [3:0]             nzcvOut,
  output logic                   flagWe
);
  localparam int BPL   = LANE_W / 8;
  localparam int VEC_W = LANES * LANE_W;
  localparam int NBYTE = VEC_W / 8;

  logic [LANES:0]   chain;
  logic [VEC_W-1:0] rawSum;
  logic [VEC_W-1:0] mergedDest;
  logic [3:0]       nzcvNext;

  assign chain[0] = strobes.carryInit;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] opA;
    logic [LANE_W-1:0] opB;
    logic [LANE_W:0]   laneSum;
    assign laneActive[k] = byteMask[k*BPL];
    assign opA = srcA[k*LANE_W +: LANE_W];
    assign opB = srcB[k*LANE_W +: LANE_W] ^ {LANE_W{strobes.inv}};
    assign laneSum = {1'b0, opA} + {1'b0, opB} + {{LANE_W{1'b0}}, chain[k]};
    assign rawSum[k*LANE_W +: LANE_W] = laneSum[LANE_W-1:0];
    // an inactive lane leaves the running carry untouched
    assign chain[k+1] = laneActive[k] ? laneSum[LANE_W] : chain[k];
  end

  for (genvar j = 0; j < NBYTE; j++) begin : g_byte
    assign mergedDest[j*8 +: 8] = byteMask[j] ? rawSum[j*8 +: 8] : oldDest[j*8 +: 8];
  end

  always_comb begin
    nzcvNext = nzcvIn;
    if (strobes.writeFlags) begin
      nzcvNext                  = 4'b0000;
      nzcvNext[lca_pkg::FLAG_C] = chain[LANES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      destOut <= '0;
      nzcvOut <= '0;
      flagWe  <= 1'b0;
    end else if (strobes.load) begin
      destOut <= mergedDest;
      nzcvOut <= nzcvNext;
      flagWe  <= strobes.writeFlags;
    end
  end
endmodule

// File: rtl/lane_carry_adder.sv
module lane_carry_adder #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [LANES*LANE_W-1:0]   srcA,
  input  logic [LANES*LANE_W-1:0]   srcB,
  input  logic [LANES*LANE_W-1:0]   oldDest,
  input  logic [LANES*LANE_W/8-1:0] byteMask,
  input  logic                      subMode,
  input  logic                      fixedCarry,
  input  logic                      skipFirst,
  input  logic [3:0]                nzcvIn,
  output logic [LANES*LANE_W-1:0]   destOut,
  output logic [3:0]                nzcvOut,
  output logic                      flagWe,
  output logic                      done
);
  lca_pkg::ctrlStrobes_t strobes;
  logic [LANES-1:0]      laneActive;

  lca_ctrl #(.LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .subMode(subMode),
    .fixedCarry(fixedCarry), .skipFirst(skipFirst), .nzcvIn(nzcvIn),
    .laneActive(laneActive), .strobes(strobes), .done(done)
  );

  lca_datapath #(.LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .srcA(srcA), .srcB(srcB),
    .oldDest(oldDest), .byteMask(byteMask), .nzcvIn(nzcvIn),
    .laneActive(laneActive), .destOut(destOut), .nzcvOut(nzcvOut),
    .flagWe(flagWe)
  );
endmodule

// File: rtl/lca_checker.sv
module lca_checker #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic [LANES*LANE_W-1:0]   oldDest,
  input logic [LANES*LANE_W/8-1:0] byteMask,
  input logic                      fixedCarry,
  input logic                      skipFirst,
  input logic [3:0]                nzcvIn,
  input logic [LANES*LANE_W-1:0]   destOut,
  input logic [3:0]                nzcvOut,
  input logic                      flagWe,
  input logic                      done
);
  p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(destOut) && $stable(nzcvOut) && $stable(flagWe)));
  p_flags_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flagWe |-> (nzcvOut[3] == 1'b0 && nzcvOut[2] == 1'b0 && nzcvOut[0] == 1'b0));
  p_fixed_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fixedCarry && !skipFirst) |=> flagWe);
  p_idle_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && byteMask == '0 && !(fixedCarry && !skipFirst)) |=>
      (!flagWe && nzcvOut == $past(nzcvIn)));
  p_empty_mask_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && byteMask == '0) |=> destOut == $past(oldDest));
endmodule

bind lane_carry_adder lca_checker #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (.*);

// File: tb/lane_carry_adder_tb.sv
module lane_carry_adder_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] srcA = '0, srcB = '0, oldDest = '0;
  logic [15:0]  byteMask = '0;
  logic         subMode = 1'b0, fixedCarry = 1'b0, skipFirst = 1'b0;
  logic [3:0]   nzcvIn = '0;
  logic [127:0] destOut;
  logic [3:0]   nzcvOut;
  logic         flagWe, done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  lane_carry_adder dut_i (.*);

  // independent reference for R1..R8
  function automatic void refModel(input logic [127:0] a, b, old, input logic [15:0] m,
      input logic sub, fix, skip, input logic [3:0] nz,
      output logic [127:0] d, output logic [3:0] nzo, output logic we);
    logic c;
    logic [32:0] s;
    logic [127:0] raw;
    logic eff;
    eff = fix && !skip;
    c = eff ? sub : nz[1];
    for (int k = 0; k < 4; k++) begin
      s = {1'b0, a[32*k +: 32]} + {1'b0, (sub ? ~b[32*k +: 32] : b[32*k +: 32])} + 33'(c);
      raw[32*k +: 32] = s[31:0];
      if (m[4*k]) c = s[32];
    end
    for (int j = 0; j < 16; j++) d[8*j +: 8] = m[j] ? raw[8*j +: 8] : old[8*j +: 8];
    we = ((m & 16'h1111) != 0) || eff;
    nzo = we ? {2'b00, c, 1'b0} : nz;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one request, check result one cycle later and hold one cycle after that
  task automatic runOp(input string tag, input logic [127:0] a, b, old, input logic [15:0] m,
      input logic sub, fix, skip, input logic [3:0] nz);
    logic [127:0] d;
    logic [3:0] nzo;
    logic we;
    refModel(a, b, old, m, sub, fix, skip, nz, d, nzo, we);
    @(negedge clk);
    srcA = a; srcB = b; oldDest = old; byteMask = m;
    subMode = sub; fixedCarry = fix; skipFirst = skip; nzcvIn = nz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R9 done"}, 128'(done), 128'd1);
    check({tag, " R1/R6 dest"}, destOut, d);
    check({tag, " R8 nzcv"}, 128'(nzcvOut), 128'(nzo));
    check({tag, " R7 flagWe"}, 128'(flagWe), 128'(we));
    srcA = ~a; byteMask = ~m; nzcvIn = ~nz;  // must not affect held outputs
    @(negedge clk);
    check({tag, " R9 done low"}, 128'(done), 128'd0);
    check({tag, " R9 hold"}, destOut, d);
  endtask

  initial begin
    #(5.0 * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    mismatched++; compared++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [127:0] ones;
    logic [127:0] oneV;
    logic [127:0] d1, d2;
    logic [3:0] n1, n2;
    logic w1, w2;
    void'($urandom(32'd4711));
    ones = '1;
    oneV = 128'd1;
    repeat (3) @(negedge clk);
    check("R9 reset dest", destOut, '0);
    check("R9 reset nzcv/flagWe/done", 128'({nzcvOut, flagWe, done}), '0);
    rst_n = 1'b1;

    // R1 carry ripple through every lane: all-ones plus one
    runOp("R1 ripple", ones, oneV, '0, 16'hFFFF, 1'b0, 1'b1, 1'b0, 4'b0000);
    // R5 lane 1 inactive: carry from lane 0 skips lane 1 into lane 2
    runOp("R5 passthru", ones, oneV, 128'h5555, 16'hFF0F, 1'b0, 1'b1, 1'b0, 4'b1111);
    // R6/R7 empty mask, non-fixed: no flag write, dest unchanged
    runOp("R7 empty", ones, ones, 128'hDEAD_BEEF, 16'h0000, 1'b0, 1'b0, 1'b0, 4'b1011);
    // R7 empty mask, fixed: still writes flags
    runOp("R7 fixed empty", ones, ones, 128'hABCD, 16'h0000, 1'b1, 1'b1, 1'b0, 4'b1101);
    // R4 skip converts fixed form: empty mask means no write
    runOp("R4 skip empty", ones, ones, 128'h1234, 16'h0000, 1'b1, 1'b1, 1'b1, 4'b0110);
    // R2/R3 subtract fixed carry 1: a-b with no borrow
    runOp("R2 sub", {4{32'd10}}, {4{32'd3}}, '0, 16'hFFFF, 1'b1, 1'b1, 1'b0, 4'b0000);
    // R3 flag carry in: C=1 added into lane 0 only active lane
    runOp("R3 cflag", 128'd5, 128'd6, ones, 16'h000F, 1'b0, 1'b0, 1'b0, 4'b0010);
    // R6 partial byte mask inside a lane
    runOp("R6 bytes", {4{32'h11223344}}, {4{32'h01010101}}, ones, 16'h0A5C, 1'b0, 1'b0, 1'b0, 4'b0000);

    // R4: skip with fixed equals non-fixed reference
    refModel(ones, oneV, '0, 16'hFFFF, 1'b1, 1'b1, 1'b1, 4'b0010, d1, n1, w1);
    refModel(ones, oneV, '0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 4'b0010, d2, n2, w2);
    runOp("R4 skip equiv", ones, oneV, '0, 16'hFFFF, 1'b1, 1'b1, 1'b1, 4'b0010);
    check("R4 equiv dest", destOut, d2);
    check("R4 equiv nzcv", 128'(nzcvOut), 128'(n2));

    for (int i = 0; i < 400; i++) begin
      logic [127:0] a, b, o;
      logic [15:0] m;
      logic [3:0] mode;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      o = {$urandom, $urandom, $urandom, $urandom};
      m = 16'($urandom);
      if (i % 8 == 0) m = '0;
      if (i % 8 == 1) m = '1;
      if (i % 5 == 0) b = ~a;  // long carry chains
      mode = 4'($urandom);
      runOp("rand R1-chain", a, b, o, m, mode[0], mode[1], mode[2], 4'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule